// File: doc/BRIEF.md
# Buffered Two-Channel PWM Comparator

This block produces pulse-width modulated waveforms on two channels that share one up-counter. The counter steps once for each cycle on which the prescale enable is high. It climbs from zero to a programmable top value and then returns to zero. Each channel compares the counter against its own active compare value. From that comparison it derives two waveforms:

- a true waveform that rises as the period starts and falls at the match;
- a complementary waveform that rises one counter step after the match and falls when the period ends.

A 2-bit mode field per channel selects which of these waveforms reach the channel's two pins.

Software writes compare values into a holding register. A holding value becomes active only on the counter step that wraps from top to zero. Pulse width therefore changes only at a period boundary, and no period is ever cut short or stretched. A read of a compare address always returns the holding value, so the most recent write reads back even before it is active.

The register port has no back-pressure. A write is accepted on every cycle where the write strobe is high, and read data is a combinational function of the address. The prescale enable and the mode fields are plain level inputs.

Top module: `pwm_pair_buffered`

## Requirements
- R1: After reset the counter, both holding registers and both active compare values are 0, the top register is 0xFF, and every pin data output is 0 until the first enabled counter step.
- R2: The counter changes only on cycles with `tick` high. On such a cycle it goes from the top value to 0, and from any other value to that value plus one.
- R3: A write to a compare address changes only the holding register. The active compare value takes the holding value on the `tick` cycle where the counter equals top, and at no other time.
- R4: Register addresses are 0 for channel 0 compare, 1 for channel 1 compare, and 2 for top. Address 3 reads as 0. A compare address reads back its holding value, and a write to top takes effect at once.
- R5: When several compare writes land inside one period, only the last one becomes active at the next wrap.
- R6: A compare write in the same cycle as the wrapping `tick` is kept in the holding register. The period that starts on that wrap still uses the previous active value. The new value becomes active at the following wrap.
- R7: With an active value c where 0 < c < top, the true waveform is 1 while the counter is in 1..c-1 and 0 otherwise.
- R8: With an active value c where 0 < c < top, the complementary waveform is 1 while the counter is in c+1..top and 0 otherwise. Its rising edge therefore comes one counter step after the match.
- R9: An active value of 0 holds the true waveform at 0 and the complementary waveform at 1. An active value equal to top holds the true waveform at 1 and the complementary waveform at 0. These levels are set from the first `tick` after the value becomes active.
- R10: The mode field `ch_mode[2i+1:2i]` of channel i selects the pins:
  - 01: `pwm_out` carries the true waveform and `pwm_out_n` the complementary waveform, and both enables are 1.
  - 10: `pwm_out` carries the true waveform, with only `pwm_oe` high.
  - 11: `pwm_out` carries the complementary waveform, with only `pwm_oe` high.
- R11: A pin that its mode leaves unused (every pin in mode 00, and `pwm_out_n` in modes 10 and 11) drives 0 and has its enable at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Prescaled count enable |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address (0, 1 compare; 2 top) |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Read data for `reg_addr` |
| ch_mode | input | 4 | Mode fields, 2 bits per channel, channel 0 in bits 1:0 |
| pwm_out | output | 2 | True pin per channel |
| pwm_out_n | output | 2 | Complementary pin per channel |
| pwm_oe | output | 2 | Enable of `pwm_out` |
| pwm_oe_n | output | 2 | Enable of `pwm_out_n` |

## Verification
Two functions can fall in the same cycle: a software write to a compare register, and the wrap step that copies the holding value into the active register.

The bench provokes this by counting its own ticks, so that a write is issued on exactly the tick where the counter sits at top. It then judges the outcome at the ports:

- the waveform for the whole next period must still match the old compare value;
- the new value must read back at once;
- the waveform must switch to the new value only one period later.

A sweep over small top values, all compare values and all modes checks the steady waveform at every counter position. Idle cycles are inserted between ticks throughout.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
  typedef enum logic [1:0] {
    MODE_OFF  = 2'b00,
    MODE_BOTH = 2'b01,
    MODE_TRUE = 2'b10,
    MODE_INV  = 2'b11
  } pwm_mode_e;
endpackage

// File: rtl/pwm_counter.sv
module pwm_counter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic [W-1:0] top,
  output logic [W-1:0] cnt,
  output logic [W-1:0] cnt_nxt,
  output logic         wrap
);
  logic [W-1:0] cnt_q;
  logic         at_top;

  always_comb begin
    at_top  = (cnt_q == top);
    cnt_nxt = at_top ? '0 : cnt_q + 1'b1;
    wrap    = tick && at_top;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt_q <= '0;
    else if (tick) cnt_q <= cnt_nxt;
  end

  assign cnt = cnt_q;
endmodule

// File: rtl/pwm_channel.sv
module pwm_channel
  import pwm_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         wrap,
  input  logic [W-1:0] cnt,
  input  logic [W-1:0] cnt_nxt,
  input  logic [W-1:0] top,
  input  logic         wr_en,
  input  logic [W-1:0] wdata,
  input  logic [1:0]   mode,
  output logic [W-1:0] hold,
  output logic         pin,
  output logic         pin_n,
  output logic         oe,
  output logic         oe_n
);
  localparam logic [W-1:0] ONE = W'(1);

  logic [W-1:0] hold_q, act_q;
  logic         tw_q, cw_q;
  pwm_mode_e    m;

  // holding register: last write wins
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     hold_q <= '0;
    else if (wr_en) hold_q <= wdata;
  end

  // active compare value moves only on the wrap step
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    act_q <= '0;
    else if (wrap) act_q <= hold_q;
  end

  // waveform registers, evaluated against the count being entered
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tw_q <= 1'b0;
      cw_q <= 1'b0;
    end else if (tick) begin
      if (act_q == '0) begin
        tw_q <= 1'b0;
        cw_q <= 1'b1;
      end else if (act_q == top) begin
        tw_q <= 1'b1;
        cw_q <= 1'b0;
      end else begin
        if (cnt_nxt == act_q)   tw_q <= 1'b0;
        else if (cnt_nxt == ONE) tw_q <= 1'b1;
        if (cnt == act_q)       cw_q <= 1'b1;
        else if (cnt_nxt == '0) cw_q <= 1'b0;
      end
    end
  end

  // pin routing by mode
  always_comb begin
    m     = pwm_mode_e'(mode);
    oe    = (m != MODE_OFF);
    oe_n  = (m == MODE_BOTH);
    pin   = oe ? ((m == MODE_INV) ? cw_q : tw_q) : 1'b0;
    pin_n = oe_n ? cw_q : 1'b0;
  end

  assign hold = hold_q;
endmodule

// File: rtl/pwm_pair_buffered.sv
module pwm_pair_buffered #(
  parameter int W   = 8,
  parameter int NCH = 2,
  localparam int AW = $clog2(NCH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             reg_wr,
  input  logic [AW-1:0]    reg_addr,
  input  logic [W-1:0]     reg_wdata,
  output logic [W-1:0]     reg_rdata,
  input  logic [2*NCH-1:0] ch_mode,
  output logic [NCH-1:0]   pwm_out,
  output logic [NCH-1:0]   pwm_out_n,
  output logic [NCH-1:0]   pwm_oe,
  output logic [NCH-1:0]   pwm_oe_n
);
  localparam logic [AW-1:0] TOP_ADDR = AW'(NCH);

  logic [W-1:0] top_q;
  logic [W-1:0] cnt_q, cnt_nxt;
  logic         wrap;
  logic [W-1:0] hold_w [NCH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                              top_q <= '1;
    else if (reg_wr && reg_addr == TOP_ADDR) top_q <= reg_wdata;
  end

  pwm_counter #(.W(W)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tick),
    .top     (top_q),
    .cnt     (cnt_q),
    .cnt_nxt (cnt_nxt),
    .wrap    (wrap)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    pwm_channel #(.W(W)) u_ch (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick    (tick),
      .wrap    (wrap),
      .cnt     (cnt_q),
      .cnt_nxt (cnt_nxt),
      .top     (top_q),
      .wr_en   (reg_wr && reg_addr == AW'(i)),
      .wdata   (reg_wdata),
      .mode    (ch_mode[2*i +: 2]),
      .hold    (hold_w[i]),
      .pin     (pwm_out[i]),
      .pin_n   (pwm_out_n[i]),
      .oe      (pwm_oe[i]),
      .oe_n    (pwm_oe_n[i])
    );
  end

  always_comb begin
    reg_rdata = '0;
    for (int i = 0; i < NCH; i++)
      if (reg_addr == AW'(i)) reg_rdata = hold_w[i];
    if (reg_addr == TOP_ADDR) reg_rdata = top_q;
  end
endmodule

// File: rtl/pwm_pair_chk.sv
module pwm_pair_chk #(
  parameter int W   = 8,
  parameter int NCH = 2,
  localparam int AW = $clog2(NCH + 1)
) (
  input logic           clk,
  input logic           rst_n,
  input logic           tick,
  input logic           reg_wr,
  input logic [AW-1:0]  reg_addr,
  input logic [W-1:0]   reg_wdata,
  input logic [W-1:0]   reg_rdata,
  input logic [NCH-1:0] pwm_out,
  input logic [NCH-1:0] pwm_out_n,
  input logic [NCH-1:0] pwm_oe,
  input logic [NCH-1:0] pwm_oe_n,
  input logic [W-1:0]   cnt_q,
  input logic [W-1:0]   top_q
);
  a_r2_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(cnt_q));

  a_r2_wrap_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && cnt_q == top_q) |=> (cnt_q == '0));

  a_r4_readback: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == '0) |=> (reg_addr != '0 || reg_rdata == $past(reg_wdata)));

  for (genvar i = 0; i < NCH; i++) begin : g_pin
    a_r11_true_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !pwm_oe[i] |-> !pwm_out[i]);
    a_r11_comp_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !pwm_oe_n[i] |-> !pwm_out_n[i]);
    a_r10_comp_needs_true: assert property (@(posedge clk) disable iff (!rst_n)
      pwm_oe_n[i] |-> pwm_oe[i]);
  end
endmodule

bind pwm_pair_buffered pwm_pair_chk #(.W(W), .NCH(NCH)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .tick      (tick),
  .reg_wr    (reg_wr),
  .reg_addr  (reg_addr),
  .reg_wdata (reg_wdata),
  .reg_rdata (reg_rdata),
  .pwm_out   (pwm_out),
  .pwm_out_n (pwm_out_n),
  .pwm_oe    (pwm_oe),
  .pwm_oe_n  (pwm_oe_n),
  .cnt_q     (cnt_q),
  .top_q     (top_q)
);

// File: tb/pwm_pair_buffered_tb.sv
module pwm_pair_buffered_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic       reg_wr = 1'b0;
  logic [1:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic [3:0] ch_mode = '0;
  logic [1:0] pwm_out, pwm_out_n, pwm_oe, pwm_oe_n;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  pwm_pair_buffered u_dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .ch_mode(ch_mode), .pwm_out(pwm_out), .pwm_out_n(pwm_out_n),
    .pwm_oe(pwm_oe), .pwm_oe_n(pwm_oe_n)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    #1;
  endtask

  task automatic do_reset();
    tick = 0; reg_wr = 0; ch_mode = '0;
    rst_n = 0;
    cyc(); cyc();
    rst_n = 1;
    cyc();
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    cyc();
    reg_wr = 0;
  endtask

  // one enabled step followed by one idle cycle
  task automatic step();
    tick = 1; cyc();
    tick = 0; cyc();
  endtask

  function automatic bit exp_t(int k, int c, int t);
    if (c == 0) return 1'b0;
    if (c == t) return 1'b1;
    return (k >= 1 && k < c);
  endfunction

  function automatic bit exp_c(int k, int c, int t);
    if (c == 0) return 1'b1;
    if (c == t) return 1'b0;
    return (k > c);
  endfunction

  // check one channel's pins against mode m and the expected waveforms
  task automatic chk_pins(int ch, int m, bit tw, bit cw, string tag);
    bit eo, eon, eoe, eoen;
    case (m)
      0:       begin eo = 0;  eon = 0;  eoe = 0; eoen = 0; end
      1:       begin eo = tw; eon = cw; eoe = 1; eoen = 1; end
      2:       begin eo = tw; eon = 0;  eoe = 1; eoen = 0; end
      default: begin eo = cw; eon = 0;  eoe = 1; eoen = 0; end
    endcase
    chk(pwm_out[ch] == eo, {tag, " R7/R8/R10 pwm_out"}, int'(pwm_out[ch]), int'(eo));
    chk(pwm_out_n[ch] == eon, {tag, " R8 R11 pwm_out_n"}, int'(pwm_out_n[ch]), int'(eon));
    chk(pwm_oe[ch] == eoe, {tag, " R10 pwm_oe"}, int'(pwm_oe[ch]), int'(eoe));
    chk(pwm_oe_n[ch] == eoen, {tag, " R11 pwm_oe_n"}, int'(pwm_oe_n[ch]), int'(eoen));
  endtask

  initial begin
    // R1: reset state
    do_reset();
    chk(pwm_out == 0 && pwm_out_n == 0, "R1 pins low", int'({pwm_out, pwm_out_n}), 0);
    ch_mode = 4'b0101; #1;
    chk(pwm_out == 0 && pwm_out_n == 0, "R1 pins low before tick", int'({pwm_out, pwm_out_n}), 0);
    reg_addr = 2'd2; #1;
    chk(reg_rdata == 8'hFF, "R1 top reset", reg_rdata, 255);
    reg_addr = 2'd0; #1;
    chk(reg_rdata == 8'h00, "R1 hold0 reset", reg_rdata, 0);
    reg_addr = 2'd1; #1;
    chk(reg_rdata == 8'h00, "R1 hold1 reset", reg_rdata, 0);

    // R4: address map and readback
    wr(2'd0, 8'h5A);
    wr(2'd1, 8'hA5);
    reg_addr = 2'd0; #1;
    chk(reg_rdata == 8'h5A, "R4 read ch0", reg_rdata, 8'h5A);
    reg_addr = 2'd1; #1;
    chk(reg_rdata == 8'hA5, "R4 read ch1", reg_rdata, 8'hA5);
    reg_addr = 2'd3; #1;
    chk(reg_rdata == 8'h00, "R4 read addr3", reg_rdata, 0);
    wr(2'd2, 8'd9);
    reg_addr = 2'd2; #1;
    chk(reg_rdata == 8'd9, "R4 top write", reg_rdata, 9);

    // R3 / R6: write colliding with the wrap step
    do_reset();
    ch_mode = 4'b0001;
    wr(2'd2, 8'd3);
    wr(2'd0, 8'd1);
    for (int n = 1; n <= 3; n++) begin
      step();
      chk(pwm_out[0] == 0 && pwm_out_n[0] == 1, "R3 old active before wrap",
          int'({pwm_out[0], pwm_out_n[0]}), 1);
    end
    for (int n = 4; n <= 7; n++) step();
    reg_wr = 1; reg_addr = 2'd0; reg_wdata = 8'd2; tick = 1;
    cyc();
    reg_wr = 0; tick = 0;
    cyc();                                         // n=8, k=0
    chk(reg_rdata == 8'd2, "R6 readback after colliding write", reg_rdata, 2);
    step();                                        // n=9, k=1
    chk(pwm_out[0] == 0, "R6 old value kept, true k=1", pwm_out[0], 0);
    step();                                        // n=10, k=2
    chk(pwm_out_n[0] == 1, "R6 old value kept, comp k=2", pwm_out_n[0], 1);
    step(); step();                                // n=11, n=12 (wrap)
    step();                                        // n=13, k=1
    chk(pwm_out[0] == 1, "R6 new value next period, true k=1", pwm_out[0], 1);
    step();                                        // n=14, k=2
    chk(pwm_out_n[0] == 0, "R6 new comp k=2", pwm_out_n[0], 0);
    step();                                        // n=15, k=3
    chk(pwm_out_n[0] == 1, "R8 comp k=3", pwm_out_n[0], 1);

    // sweep: R2 R5 R7 R8 R9 R10 R11
    for (int t = 1; t <= 6; t++) begin
      for (int c = 0; c <= t; c++) begin
        do_reset();
        wr(2'd2, 8'(t));
        wr(2'd0, 8'hEE);                           // overwritten below (R5)
        wr(2'd1, 8'h11);
        wr(2'd0, 8'(c));
        wr(2'd1, 8'(t - c));
        for (int n = 1; n < 3 * (t + 1); n++) begin
          step();
          if (n >= 2 * (t + 1)) begin
            int k;
            k = n % (t + 1);
            for (int m = 0; m < 4; m++) begin
              ch_mode = {2'(3 - m), 2'(m)};
              #1;
              chk_pins(0, m, exp_t(k, c, t), exp_c(k, c, t), "R2 R5 R9 ch0");
              chk_pins(1, 3 - m, exp_t(k, t - c, t), exp_c(k, t - c, t), "R9 ch1");
            end
          end
        end
        reg_addr = 2'd0; #1;
        chk(reg_rdata == 8'(c), "R5 last write held", reg_rdata, c);
      end
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL R2 watchdog actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule